// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that a memory controller places on the column bus, one per beat, for a read or write burst within an open row. A request carries a starting column, a burst-length code and an ordering choice. The block then presents one column per clock, in sequential or interleaved order, until the burst completes, is cut short or is replaced by a new request.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of columns that holds the starting column, and only the low address bits move. A full-row burst walks the whole row and wraps at the row end. It runs until a terminate request ends it. A clock-suspend input freezes the burst in place. A new request at any time abandons the current burst and starts over from the new column. Forming the DRAM commands themselves is left to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `beatValid`, `burstDone` and `modeFault` are all low.
- R2: A request (`start` high at a rising edge) makes `beatValid` high with `beatCol` equal to `startCol` from the next cycle. `blCode` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give a full-row burst. `interleave` 0 selects sequential order and 1 selects interleaved order.
- R3: A burst of length 1 yields exactly one valid beat, at the start column, with `burstDone` high on that beat.
- R4: In sequential order with length BL, beat k has column `(startCol - startCol mod BL) + ((startCol mod BL + k) mod BL)`.
- R5: In interleaved order with length BL, beat k has column `(startCol - startCol mod BL) + ((startCol mod BL) XOR k)`.
- R6: For a fixed-length burst, `burstDone` is high only on the last beat, and `beatValid` is low on the cycle after it unless a new request was taken.
- R7: A full-row burst steps the column by one modulo 2^COL_W (256 by default) every cycle. It wraps past the row end and never raises `burstDone` on its own.
- R8: `terminate` high during a valid beat raises `burstDone` in that same cycle, and `beatValid` is low on the next cycle.
- R9: A request taken during a burst discards the rest of that burst. The next cycle shows beat 0 of the new burst at its own start column.
- R10: While `suspend` is high, the current beat and its column are held, the beat index does not advance, and `burstDone` stays low for a last beat until `suspend` falls.
- R11: A full-row request with `interleave` high is run in sequential order, and `modeFault` is high on every beat of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst; truncates any burst in progress |
| startCol | input | COL_W | Starting column of the requested burst |
| blCode | input | 3 | Length code: 0→1, 1→2, 2→4, 3→8, 4..7→full row |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| terminate | input | 1 | End the current burst after the present beat |
| suspend | input | 1 | Clock-suspend: freeze the current beat |
| beatCol | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| burstDone | output | 1 | Current beat is the burst's final one |
| modeFault | output | 1 | Interleaved full-row request, executed as sequential |

## Verification
Fixed bursts are started at columns whose low bits sit at zero, in the middle and at the top of their aligned block. These starts tell a correct wrap inside the block apart from a carry that leaks into the upper bits, and for interleaved order they show whether the XOR differs from addition. A full-row burst is started two columns below the row end and run beyond 256 beats, which shows both the wrap at the row boundary and the lack of any self-termination. Truncation by terminate, restarts in mid-burst, and suspend on a middle beat and on the last beat each test how done and valid are timed against the beat index.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request, beat index to zero
    logic advance;  // step to the next beat
  } bcgStrobe_t;

  localparam int LEN_CODE_W = 3;
endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bcgStrobe_t            strobe,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] blCode,
  input  logic                  interleave,
  output logic [COL_W-1:0]      beatCol,
  output logic                  isLast,
  output logic                  fullPage,
  output logic                  faultFlag
);
  localparam int FIXED_CODES = 4;

  logic [COL_W-1:0] baseReg, idxReg, maskReg;
  logic [COL_W-1:0] maskNext;
  logic             fullNext, ilReg;
  logic [COL_W-1:0] orderBits;

  // Length code to in-block mask; full row moves every bit
  always_comb begin
    fullNext = (int'(blCode) >= FIXED_CODES);
    maskNext = '1;
    if (!fullNext) maskNext = COL_W'((1 << blCode) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      idxReg    <= '0;
      maskReg   <= '0;
      fullPage  <= 1'b0;
      ilReg     <= 1'b0;
      faultFlag <= 1'b0;
    end else if (strobe.load) begin
      baseReg   <= startCol;
      idxReg    <= '0;
      maskReg   <= maskNext;
      fullPage  <= fullNext;
      ilReg     <= interleave && !fullNext;
      faultFlag <= interleave && fullNext;
    end else if (strobe.advance) begin
      idxReg <= idxReg + 1'b1;
    end
  end

  assign orderBits = ilReg ? (baseReg ^ idxReg) : (baseReg + idxReg);

  // Bits inside the burst block take the ordered value, the rest stay put
  for (genvar b = 0; b < COL_W; b++) begin : g_colBit
    assign beatCol[b] = maskReg[b] ? orderBits[b] : baseReg[b];
  end

  assign isLast = (idxReg == maskReg);
endmodule

// File: rtl/bcg_control.sv
module bcg_control
  import bcg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       terminate,
  input  logic       suspend,
  input  logic       isLast,
  input  logic       fullPage,
  output bcgStrobe_t strobe,
  output logic       beatValid,
  output logic       burstDone
);
  logic active;
  logic naturalEnd;

  assign naturalEnd = active && isLast && !suspend && !fullPage;
  assign burstDone  = active && (terminate || naturalEnd);
  assign beatValid  = active;

  always_comb begin
    strobe.load    = start;
    strobe.advance = active && !suspend && !start;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          active <= 1'b0;
    else if (start)     active <= 1'b1;
    else if (burstDone) active <= 1'b0;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] blCode,
  input  logic                  interleave,
  input  logic                  terminate,
  input  logic                  suspend,
  output logic [COL_W-1:0]      beatCol,
  output logic                  beatValid,
  output logic                  burstDone,
  output logic                  modeFault
);
  bcgStrobe_t strobe;
  logic isLast, fullPage, faultFlag;

  bcg_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .terminate(terminate),
    .suspend(suspend), .isLast(isLast), .fullPage(fullPage),
    .strobe(strobe), .beatValid(beatValid), .burstDone(burstDone)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .blCode(blCode), .interleave(interleave), .beatCol(beatCol),
    .isLast(isLast), .fullPage(fullPage), .faultFlag(faultFlag)
  );

  assign modeFault = beatValid && faultFlag;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic             terminate,
  input logic             suspend,
  input logic [COL_W-1:0] beatCol,
  input logic             beatValid,
  input logic             burstDone,
  input logic             modeFault
);
  p_start_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (beatValid && beatCol == $past(startCol)));

  p_done_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> beatValid);

  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && !start) |=> !beatValid);

  p_term_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && terminate) |-> burstDone);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && suspend && !start && !terminate) |=> (beatValid && $stable(beatCol)));

  p_fault_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> beatValid);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
  .terminate(terminate), .suspend(suspend), .beatCol(beatCol),
  .beatValid(beatValid), .burstDone(burstDone), .modeFault(modeFault)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0] blCode = '0;
  logic interleave = 1'b0, terminate = 1'b0, suspend = 1'b0;
  logic [COL_W-1:0] beatCol;
  logic beatValid, burstDone, modeFault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .blCode(blCode), .interleave(interleave), .terminate(terminate),
    .suspend(suspend), .beatCol(beatCol), .beatValid(beatValid),
    .burstDone(burstDone), .modeFault(modeFault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input int code);
    return (code >= 4) ? ROW : (1 << code);
  endfunction

  // Expected column from the arithmetic in R4, R5, R7, R11
  function automatic int expCol(input int base, input int k, input int code, input bit il);
    int bl = lenOf(code);
    int blk = base - (base % bl);
    int off = base % bl;
    if (code >= 4) return (base + k) % ROW;
    if (il) return blk + (off ^ k);
    return blk + ((off + k) % bl);
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input int col, input int code, input bit il);
    @(negedge clk);
    start = 1'b1; startCol = COL_W'(col); blCode = 3'(code); interleave = il;
    step();
    start = 1'b0;
  endtask

  // Walk n beats, checking column, valid and done
  task automatic walk(input string tag, input int base, input int code, input bit il,
                      input int first, input int n, input bit lastDone);
    for (int k = first; k < first + n; k++) begin
      chk({tag, " valid"}, int'(beatValid), 1);
      chk({tag, " col"}, int'(beatCol), expCol(base, k, code, il));
      chk({tag, " done"}, int'(burstDone), (lastDone && k == first + n - 1) ? 1 : 0);
      if (k != first + n - 1) step();
    end
  endtask

  task automatic t_reset();
    step();
    chk("R1 valid in reset", int'(beatValid), 0);
    chk("R1 done in reset", int'(burstDone), 0);
    @(negedge clk); rstN = 1'b1; #1;
    chk("R1 valid after reset", int'(beatValid), 0);
    chk("R1 fault after reset", int'(modeFault), 0);
  endtask

  task automatic t_single();
    issue(8'h35, 0, 1'b0);
    walk("R3 single", 8'h35, 0, 1'b0, 0, 1, 1'b1);
    step();
    chk("R3 single one beat", int'(beatValid), 0);
  endtask

  task automatic t_sequential();
    issue(8'h16, 2, 1'b0);
    chk("R2 first col", int'(beatCol), 8'h16);
    walk("R4 seq4", 8'h16, 2, 1'b0, 0, 4, 1'b1);
    step();
    chk("R6 valid after done", int'(beatValid), 0);
    issue(8'h2D, 3, 1'b0);
    walk("R4 seq8", 8'h2D, 3, 1'b0, 0, 8, 1'b1);
    step();
    chk("R6 seq8 ends", int'(beatValid), 0);
  endtask

  task automatic t_interleaved();
    issue(8'h2D, 3, 1'b1);
    walk("R5 il8", 8'h2D, 3, 1'b1, 0, 8, 1'b1);
    step();
    chk("R6 il8 ends", int'(beatValid), 0);
    issue(8'h43, 1, 1'b1);
    walk("R5 il2", 8'h43, 1, 1'b1, 0, 2, 1'b1);
    step();
    issue(8'h7A, 2, 1'b1);
    walk("R5 il4", 8'h7A, 2, 1'b1, 0, 4, 1'b1);
    step();
  endtask

  task automatic t_fullTerminate();
    issue(8'hFE, 7, 1'b0);
    walk("R7 full", 8'hFE, 7, 1'b0, 0, 300, 1'b0);
    chk("R7 no fault", int'(modeFault), 0);
    terminate = 1'b1; #1;
    chk("R8 done on terminate", int'(burstDone), 1);
    step();
    terminate = 1'b0; #1;
    chk("R8 valid after terminate", int'(beatValid), 0);
    issue(8'h20, 3, 1'b0);
    walk("R8 seq8 pre", 8'h20, 3, 1'b0, 0, 2, 1'b0);
    terminate = 1'b1; #1;
    chk("R8 fixed terminate done", int'(burstDone), 1);
    step();
    terminate = 1'b0; #1;
    chk("R8 fixed terminate ends", int'(beatValid), 0);
  endtask

  task automatic t_restart();
    issue(8'h10, 3, 1'b0);
    walk("R9 before", 8'h10, 3, 1'b0, 0, 3, 1'b0);
    start = 1'b1; startCol = 8'h73; blCode = 3'd2; interleave = 1'b0;
    step();
    start = 1'b0;
    walk("R9 after", 8'h73, 2, 1'b0, 0, 4, 1'b1);
    step();
    chk("R9 restarted ends", int'(beatValid), 0);
  endtask

  task automatic t_suspend();
    issue(8'h08, 2, 1'b0);
    walk("R10 pre", 8'h08, 2, 1'b0, 0, 2, 1'b0);
    suspend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10 held valid", int'(beatValid), 1);
      chk("R10 held col", int'(beatCol), 8'h09);
    end
    suspend = 1'b0;
    step();
    walk("R10 resume", 8'h08, 2, 1'b0, 2, 1, 1'b0);
    step();
    chk("R10 last col", int'(beatCol), 8'h0B);
    suspend = 1'b1; #1;
    chk("R10 done deferred", int'(burstDone), 0);
    step();
    chk("R10 last held", int'(beatValid), 1);
    chk("R10 last col held", int'(beatCol), 8'h0B);
    suspend = 1'b0; #1;
    chk("R10 done released", int'(burstDone), 1);
    step();
    chk("R10 ends", int'(beatValid), 0);
  endtask

  task automatic t_fault();
    issue(8'hF0, 5, 1'b1);
    for (int k = 0; k < 20; k++) begin
      chk("R11 fault flag", int'(modeFault), 1);
      chk("R11 seq col", int'(beatCol), expCol(8'hF0, k, 5, 1'b0));
      step();
    end
    terminate = 1'b1;
    step();
    terminate = 1'b0; #1;
    chk("R11 fault clears", int'(modeFault), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_sequential();
    t_interleaved();
    t_fullTerminate();
    t_restart();
    t_suspend();
    t_fault();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule